// File: doc/BRIEF.md
# Data Lane High-Speed Burst Sequencer

This block frames one high-speed burst on a single data lane of a serial camera/display link transmitter. While the lane is idle it sits in the Stop state (LP-11). When a payload byte is offered and the clock lane reports that its high-speed clock is running, the block steps through the low-power request (LP-01) and bridge (LP-00) states. It then drives HS-0 for a programmable time, sends one sync byte, and streams payload bytes to the serializer one per byte-clock cycle. After the final byte it holds the lane in the complement of the last transmitted bit for a trail time. It returns to LP-11 for the exit time and then pulses a done flag so that the clock lane sequencer can begin its own post count.

Every phase length is an input counted in byte-clock cycles, so software computes the values from the bit rate. A programmed length of zero is treated as one cycle. Every low-power phase that the block times is held for at least the LPX length. Payload is taken with a ready/valid handshake. The serializer sends each byte least significant bit first, which makes bit 7 the last bit on the wire. If valid drops while the block still wants data, the burst is closed early and the condition is flagged.

The state machine has eight states. ST_STOP (LP-11, idle) goes to ST_REQ when s_valid and clk_ready are both high. ST_REQ (LP-01) goes to ST_PREP when its timer expires. ST_PREP (LP-00) goes to ST_ZERO when its timer expires. ST_ZERO (HS-0) goes to ST_SYNC when its timer expires. ST_SYNC (sync byte) goes to ST_DATA if a byte is accepted and to ST_TRAIL on underrun. ST_DATA (payload) stays in ST_DATA while bytes keep arriving, and goes to ST_TRAIL after the last byte or on underrun. ST_TRAIL (complement level) goes to ST_EXIT when its timer expires. ST_EXIT (LP-11) goes back to ST_STOP when its timer expires.

Top module: `hs_lane_burst`

## Requirements
- R1: After reset, and whenever no burst is active, the lane drives LP-11 (lp_p=1, lp_n=1) with hs_en=0, and s_ready, lane_done and underrun_err are all 0.
- R2: A burst starts only from Stop, and only in a cycle where s_valid and clk_ready are both high. In that case LP-01 appears in the next cycle. While clk_ready is low the lane stays in LP-11 whatever s_valid does.
- R3: LP-01 (lp_p=0, lp_n=1) lasts max(cfg_lpx,1) cycles.
- R4: LP-00 with hs_en=0 lasts max(cfg_prep, cfg_lpx, 1) cycles.
- R5: HS-0 (hs_en=1, hs_byte=8'h00) lasts max(cfg_zero,1) cycles. Both lp outputs are 0 in every cycle with hs_en=1.
- R6: After HS-0, hs_byte carries the sync value 8'hB8 for one cycle with s_ready high. A byte accepted at a clock edge appears on hs_byte in the next cycle, one byte per cycle, in order.
- R7: s_ready is low in the cycle that shows a byte accepted with s_last=1. The trail begins in the next cycle.
- R8: The trail lasts max(cfg_trail,1) cycles with hs_en=1. Every bit of hs_byte equals the inverse of bit 7 of the last byte sent on the wire, so 8'h00 follows a byte with bit 7 set and 8'hFF follows a byte with bit 7 clear.
- R9: After the trail, LP-11 with hs_en=0 lasts max(cfg_exit, cfg_lpx, 1) cycles.
- R10: lane_done is high for exactly the first cycle after the exit phase. A new burst request that is present in that same cycle is accepted, with LP-01 in the next cycle.
- R11: If s_valid is low while s_ready is high, underrun_err is high for exactly the first trail cycle. The burst then closes through trail and exit, and the trail level is the inverse of bit 7 of the last byte sent. That last byte is the sync byte when no payload was accepted, which gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ready | input | 1 | High-speed clock on the clock lane is running |
| cfg_lpx | input | CW | LP state minimum length, cycles |
| cfg_prep | input | CW | LP-00 prepare length, cycles |
| cfg_zero | input | CW | HS-0 length, cycles |
| cfg_trail | input | CW | Trail length, cycles |
| cfg_exit | input | CW | LP-11 exit length, cycles |
| s_data | input | DW | Payload byte |
| s_valid | input | 1 | Payload byte valid / burst request |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Payload byte is taken at this edge |
| lp_p | output | 1 | Low-power driver, positive line |
| lp_n | output | 1 | Low-power driver, negative line |
| hs_en | output | 1 | High-speed driver enabled |
| hs_byte | output | DW | Byte to the serializer, LSB first |
| lane_done | output | 1 | One-cycle pulse after the exit phase |
| underrun_err | output | 1 | One-cycle pulse on a payload underrun |

## Verification
Two functions can land in the same cycle. The lane_done pulse of one burst can coincide with the entry request of the next, and an underrun flag can coincide with the switch from sync to trail. The first case is provoked by raising s_valid for a second burst while the first is still in its trail. The scoreboard then expects LP-01 in the cycle that follows lane_done, with no idle cycle between them. The second case is provoked by dropping s_valid before the sync edge, and the bench expects an 8'h00 trail with the error flag in its first cycle.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    typedef enum logic [2:0] {
        ST_STOP,
        ST_REQ,
        ST_PREP,
        ST_ZERO,
        ST_SYNC,
        ST_DATA,
        ST_TRAIL,
        ST_EXIT
    } hsb_state_e;
endpackage

// File: rtl/hsb_phase_timer.sv
module hsb_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_len,
    output logic          expired
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    // Loading len-1 makes the phase last exactly len cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_len - ONE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/hsb_byte_hold.sv
module hsb_byte_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    input  logic          to_trail,
    input  logic          wire_msb,
    output logic [DW-1:0] data_q,
    output logic          last_q,
    output logic          trail_lvl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= '0;
            last_q    <= 1'b0;
            trail_lvl <= 1'b0;
        end else begin
            if (take) begin
                data_q <= in_data;
                last_q <= in_last;
            end
            // The MSB is the final bit serialized; the trail holds its inverse.
            if (to_trail) begin
                trail_lvl <= ~wire_msb;
            end
        end
    end
endmodule

// File: rtl/hs_lane_burst.sv
module hs_lane_burst
    import hsb_pkg::*;
#(
    parameter int             DW        = 8,
    parameter int             CW        = 8,
    parameter logic [DW-1:0]  SYNC_WORD = DW'(8'hB8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_ready,
    input  logic [CW-1:0] cfg_lpx,
    input  logic [CW-1:0] cfg_prep,
    input  logic [CW-1:0] cfg_zero,
    input  logic [CW-1:0] cfg_trail,
    input  logic [CW-1:0] cfg_exit,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    output logic          lp_p,
    output logic          lp_n,
    output logic          hs_en,
    output logic [DW-1:0] hs_byte,
    output logic          lane_done,
    output logic          underrun_err
);
    localparam logic [CW-1:0] ONE = CW'(1);

    hsb_state_e    state_q, state_d;
    logic          expired, take, underrun, to_trail, load;
    logic          last_q, trail_lvl, done_q, err_q;
    logic [DW-1:0] data_q;
    logic [CW-1:0] lpx_eff, load_len;

    function automatic logic [CW-1:0] at_least(input logic [CW-1:0] v,
                                               input logic [CW-1:0] floor_v);
        return (v > floor_v) ? v : floor_v;
    endfunction

    assign lpx_eff = at_least(cfg_lpx, ONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (s_valid && clk_ready) state_d = ST_REQ;
            ST_REQ:   if (expired) state_d = ST_PREP;
            ST_PREP:  if (expired) state_d = ST_ZERO;
            ST_ZERO:  if (expired) state_d = ST_SYNC;
            ST_SYNC:  state_d = s_valid ? ST_DATA : ST_TRAIL;
            ST_DATA:  if (last_q || !s_valid) state_d = ST_TRAIL;
            ST_TRAIL: if (expired) state_d = ST_EXIT;
            ST_EXIT:  if (expired) state_d = ST_STOP;
            default:  state_d = ST_STOP;
        endcase
    end

    // Phase length for the state being entered; LP phases never shorter than LPX.
    always_comb begin
        unique case (state_d)
            ST_REQ:   load_len = lpx_eff;
            ST_PREP:  load_len = at_least(cfg_prep, lpx_eff);
            ST_ZERO:  load_len = at_least(cfg_zero, ONE);
            ST_TRAIL: load_len = at_least(cfg_trail, ONE);
            ST_EXIT:  load_len = at_least(cfg_exit, lpx_eff);
            default:  load_len = ONE;
        endcase
    end

    assign load     = (state_d != state_q);
    assign s_ready  = (state_q == ST_SYNC) || ((state_q == ST_DATA) && !last_q);
    assign take     = s_ready && s_valid;
    assign underrun = s_ready && !s_valid;
    assign to_trail = (state_d == ST_TRAIL) && (state_q != ST_TRAIL);

    hsb_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_len (load_len),
        .expired  (expired)
    );

    hsb_byte_hold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .in_data   (s_data),
        .in_last   (s_last),
        .to_trail  (to_trail),
        .wire_msb  (hs_byte[DW-1]),
        .data_q    (data_q),
        .last_q    (last_q),
        .trail_lvl (trail_lvl)
    );

    // Flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_EXIT) && expired;
            err_q  <= underrun;
        end
    end

    assign lane_done    = done_q;
    assign underrun_err = err_q;

    // Line outputs
    always_comb begin
        lp_p    = 1'b0;
        lp_n    = 1'b0;
        hs_en   = 1'b0;
        hs_byte = '0;
        unique case (state_q)
            ST_STOP, ST_EXIT: begin
                lp_p = 1'b1;
                lp_n = 1'b1;
            end
            ST_REQ:   lp_n = 1'b1;
            ST_PREP:  ;
            ST_ZERO:  hs_en = 1'b1;
            ST_SYNC: begin
                hs_en   = 1'b1;
                hs_byte = SYNC_WORD;
            end
            ST_DATA: begin
                hs_en   = 1'b1;
                hs_byte = data_q;
            end
            ST_TRAIL: begin
                hs_en   = 1'b1;
                hs_byte = {DW{trail_lvl}};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hs_lane_burst_chk.sv
module hs_lane_burst_chk
    import hsb_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_ready,
    input logic          s_valid,
    input logic          s_ready,
    input logic          lp_p,
    input logic          lp_n,
    input logic          hs_en,
    input logic [DW-1:0] hs_byte,
    input logic          lane_done,
    input logic          underrun_err,
    input logic [CW-1:0] cfg_lpx,
    input hsb_state_e    state_q
);
    logic [1:0]  pair_q;
    logic        hs_q;
    logic [CW:0] run_q;
    logic [CW:0] lpx_min;

    assign lpx_min = (cfg_lpx == '0) ? (CW+1)'(1) : {1'b0, cfg_lpx};

    // Length of the current LP pair run, counted in cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= 2'b11;
            hs_q   <= 1'b0;
            run_q  <= '0;
        end else begin
            pair_q <= {lp_p, lp_n};
            hs_q   <= hs_en;
            if (hs_en || ({lp_p, lp_n} != pair_q)) begin
                run_q <= (CW+1)'(1);
            end else if (run_q != '1) begin
                run_q <= run_q + (CW+1)'(1);
            end
        end
    end

    // R3 / R4: a request or bridge state is never left before LPX cycles
    p_lp_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_en || ({lp_p, lp_n} != pair_q)) && !hs_q && (pair_q != 2'b11))
            |-> (run_q >= lpx_min));

    p_hs_lp_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (!lp_p && !lp_n));

    p_ready_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> hs_en);

    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_p && lp_n && $past(lp_p && lp_n && !hs_en)) |-> $past(s_valid && clk_ready));

    p_trail_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TRAIL) && ($past(state_q) == ST_TRAIL)) |-> $stable(hs_byte));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lane_done |=> !lane_done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lane_done |-> (lp_p && lp_n && !hs_en && $past(lp_p && lp_n && !hs_en)));

    p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_err |-> ((state_q == ST_TRAIL) && $past(s_ready && !s_valid)));
endmodule

bind hs_lane_burst hs_lane_burst_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_ready    (clk_ready),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .lp_p         (lp_p),
    .lp_n         (lp_n),
    .hs_en        (hs_en),
    .hs_byte      (hs_byte),
    .lane_done    (lane_done),
    .underrun_err (underrun_err),
    .cfg_lpx      (cfg_lpx),
    .state_q      (state_q)
);

// File: tb/hs_lane_burst_bench.sv
module hs_lane_burst_bench;
    typedef struct packed {
        logic       p;
        logic       n;
        logic       hs;
        logic [7:0] b;
        logic       rdy;
        logic       done;
        logic       err;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_ready = 1'b0;
    logic [7:0] cfg_lpx = 8'd1, cfg_prep = 8'd1, cfg_zero = 8'd1, cfg_trail = 8'd1, cfg_exit = 8'd1;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready, lp_p, lp_n, hs_en, lane_done, underrun_err;
    logic [7:0] hs_byte;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;
    exp_t exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    hs_lane_burst u_hs_lane_burst (
        .clk(clk), .rst_n(rst_n), .clk_ready(clk_ready),
        .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep), .cfg_zero(cfg_zero),
        .cfg_trail(cfg_trail), .cfg_exit(cfg_exit),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en), .hs_byte(hs_byte),
        .lane_done(lane_done), .underrun_err(underrun_err)
    );

    function automatic exp_t observed();
        exp_t o;
        o = '{p: lp_p, n: lp_n, hs: hs_en, b: (hs_en ? hs_byte : 8'h00),
              rdy: s_ready, done: lane_done, err: underrun_err};
        return o;
    endfunction

    task automatic compare(input exp_t e, input string tag);
        exp_t o;
        o = observed();
        n_cmp++;
        if (o !== e) begin
            n_bad++;
            $display("FAIL %s t=%0t actual p%b n%b hs%b b=%h rdy%b done%b err%b expected p%b n%b hs%b b=%h rdy%b done%b err%b",
                     tag, $time, o.p, o.n, o.hs, o.b, o.rdy, o.done, o.err,
                     e.p, e.n, e.hs, e.b, e.rdy, e.done, e.err);
        end
    endtask

    task automatic push(input logic p, input logic n, input logic hs, input logic [7:0] b,
                        input logic rdy, input logic done, input logic err, input string tag);
        exp_t e;
        e = '{p: p, n: n, hs: hs, b: (hs ? b : 8'h00), rdy: rdy, done: done, err: err};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expected item per cycle, or checks idle when the queue is empty.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                if (exp_q.size() > 0) begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    compare(e, t);
                end else begin
                    compare('{p: 1'b1, n: 1'b1, hs: 1'b0, b: 8'h00, rdy: 1'b0, done: 1'b0, err: 1'b0}, "R1 idle");
                end
            end
        end
    end

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Driver: pushes the cycle-by-cycle expectation, then feeds the burst.
    // k < 0: normal burst of n bytes; k >= 0: valid drops after k accepted bytes.
    task automatic burst(input bit chained, input int hold,
                         input int l, input int p, input int z, input int t, input int x,
                         input logic [7:0] b [8], input int n, input int k);
        int         el, ep, ez, et, ex, nb, i, lim;
        bit         under, take;
        logic [7:0] lastb, tb;
        if (!chained) begin
            while (exp_q.size() != 0) @(negedge clk);
            cfg_lpx = 8'(l); cfg_prep = 8'(p); cfg_zero = 8'(z);
            cfg_trail = 8'(t); cfg_exit = 8'(x);
        end
        under = (k >= 0);
        el = imax(l, 1); ep = imax(p, el); ez = imax(z, 1); et = imax(t, 1); ex = imax(x, el);
        nb = under ? k : n;
        lastb = under ? ((k > 0) ? b[k-1] : 8'hB8) : b[n-1];
        tb = lastb[7] ? 8'h00 : 8'hFF;
        for (int c = 0; c < hold; c++) push(1, 1, 0, 8'h00, 0, 0, 0, "R2 held off by clk_ready");
        for (int c = 0; c < el; c++) push(0, 1, 0, 8'h00, 0, 0, 0, "R3 LP-01");
        for (int c = 0; c < ep; c++) push(0, 0, 0, 8'h00, 0, 0, 0, "R4 LP-00");
        for (int c = 0; c < ez; c++) push(0, 0, 1, 8'h00, 0, 0, 0, "R5 HS-0");
        push(0, 0, 1, 8'hB8, 1, 0, 0, "R6 sync");
        for (int j = 0; j < nb; j++) begin
            if (!under && j == n - 1) push(0, 0, 1, b[j], 0, 0, 0, "R7 last byte");
            else                      push(0, 0, 1, b[j], 1, 0, 0, "R6 payload");
        end
        for (int c = 0; c < et; c++) begin
            if (under && c == 0) push(0, 0, 1, tb, 0, 0, 1, "R11 underrun trail");
            else                 push(0, 0, 1, tb, 0, 0, 0, "R8 trail");
        end
        for (int c = 0; c < ex; c++) push(1, 1, 0, 8'h00, 0, 0, 0, "R9 exit");
        push(1, 1, 0, 8'h00, 0, 1, 0, "R10 done");

        s_valid = 1'b1;
        s_data  = b[0];
        s_last  = !under && (n == 1);
        clk_ready = (hold == 0);
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            clk_ready = 1'b1;
        end
        i = 0;
        lim = under ? k : n;
        while (i < lim) begin
            take = s_ready;
            @(negedge clk);
            if (take) begin
                i++;
                if (i < 8) begin
                    s_data = b[i];
                    s_last = !under && (i == n - 1);
                end
            end
        end
        if (under) begin
            while (!s_ready) @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    initial begin
        logic [7:0] d [8];
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        compare('{p: 1'b1, n: 1'b1, hs: 1'b0, b: 8'h00, rdy: 1'b0, done: 1'b0, err: 1'b0}, "R1 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2..R10: burst held off by clk_ready, last byte bit7=1 -> trail 00
        d = '{8'h11, 8'h22, 8'h83, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        burst(0, 4, 3, 5, 4, 6, 7, d, 3, -1);

        // R4/R9: prepare and exit shorter than LPX are stretched; single byte -> trail FF
        d = '{8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        burst(0, 0, 5, 2, 1, 3, 2, d, 1, -1);

        // R10: next request present in the done cycle (chained bursts)
        d = '{8'h01, 8'hA5, 8'h5A, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00};
        burst(0, 0, 2, 3, 2, 4, 3, d, 4, -1);
        d = '{8'h7F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        burst(1, 0, 2, 3, 2, 4, 3, d, 1, -1);

        // R11: underrun after two bytes, zero config (all phases one cycle) -> trail FF
        d = '{8'h80, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        burst(0, 0, 0, 0, 0, 0, 0, d, 8, 2);

        // R11: underrun at the sync byte -> trail 00
        d = '{8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        burst(0, 0, 2, 2, 3, 2, 2, d, 8, 0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule